// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Clock Output

This block is a 16-bit timer/counter paired with a 16-bit reload register. Each counting step is triggered by a one-cycle tick input, and steps happen only while the run bit is set. In the plain mode the counter counts up and restarts from the reload value after it passes all-ones. An optional bidirectional mode hands the count direction to an external pin. When counting up, the counter wraps from all-ones to the reload value. When counting down, it wraps from the reload value to all-ones. Each wrap in this mode toggles a separate event flag.

A clock-output mode turns the same counter into a programmable square-wave source. The counter counts up and reloads, and each wrap toggles the output pin, which gives a 50% duty cycle. Software sets up the timer before starting it. It loads the initial count and the reload value through write strobes, selects the mode through a 2-bit mode register, and then sets the run bit through a 3-bit control register. The control register also holds the two flags, so writing it clears them.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset, the count, the reload value, the run bit, both flags, the mode register and the clock-output pin are all 0.
- R2: The count changes only when the run bit (control bit 0) is 1 and tick is 1 in the same cycle, or when software writes the count.
- R3: When mode bit 0 (bidirectional) and mode bit 1 (clock output) are both 0, each tick adds 1. A tick at all-ones loads the reload value instead and sets the overflow flag (control bit 1). The direction pin is ignored, and the event flag is unchanged.
- R4: With mode = 01 and the direction pin at 1, the count steps up as in R3. A wrap at all-ones also toggles the event flag (control bit 2).
- R5: With mode = 01 and the direction pin at 0, each tick subtracts 1. A tick taken while the count equals the reload value loads all-ones instead, sets the overflow flag and toggles the event flag. A count below the reload value wraps from 0 to all-ones with no flag change.
- R6: With mode bit 1 set, the counter counts up whatever the direction pin and mode bit 0 are. Each wrap at all-ones reloads the count and toggles the clock-output pin. The overflow flag and the event flag stay unchanged, so the output half-period is 2^16 minus the reload value in ticks.
- R7: A count write takes priority over a tick in the same cycle. A reload write changes only the reload value. A control write replaces the run bit and both flags, and takes priority over any hardware flag update in that cycle.
- R8: A mode write with bit 1 = 0 forces the clock-output pin to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per cycle it is high |
| dirUp | input | 1 | Direction pin in bidirectional mode, 1 = up |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 3 | {event flag, overflow flag, run} |
| modeWe | input | 1 | Mode register write strobe |
| modeWdata | input | 2 | {clock-output enable, bidirectional enable} |
| cntWe | input | 1 | Count write strobe |
| cntWdata | input | 16 | Count write value |
| rldWe | input | 1 | Reload register write strobe |
| rldWdata | input | 16 | Reload write value |
| count | output | 16 | Current count |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | Event flag of the bidirectional mode |
| clkOut | output | 1 | Clock-output pin |

## Verification
Every result is due exactly one cycle after the rising edge that samples the tick or write that caused it: the count, both flags and the clock-output pin are all registered, with no further pipeline stage. The bench changes inputs on the falling edge, lets one rising edge pass, and compares all four outputs on the next falling edge against a model that steps at that same edge. The R6 half-period is therefore checked as exactly 2^16 minus the reload value ticks between pin changes.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  // control register field positions
  localparam int CTRL_RUN = 0;
  localparam int CTRL_OVF = 1;
  localparam int CTRL_EXT = 2;
  localparam int CTRL_W   = 3;
  // mode register field positions
  localparam int MODE_BIDIR  = 0;
  localparam int MODE_CLKOUT = 1;
  localparam int MODE_W      = 2;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic incr;
    logic decr;
    logic rldLoad;
    logic onesLoad;
  } stepCmdT;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import updn_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  stepCmdT      cmd,
  input  logic         cntWe,
  input  logic [W-1:0] cntWdata,
  input  logic         rldWe,
  input  logic [W-1:0] rldWdata,
  output logic [W-1:0] count,
  output logic         atMax,
  output logic         atReload
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] reloadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (cntWe) begin
      count <= cntWdata;
    end else if (cmd.rldLoad) begin
      count <= reloadQ;
    end else if (cmd.onesLoad) begin
      count <= ONES;
    end else if (cmd.incr) begin
      count <= count + ONE;
    end else if (cmd.decr) begin
      count <= count - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) reloadQ <= '0;
    else if (rldWe) reloadQ <= rldWdata;
  end

  assign atMax    = (count == ONES);
  assign atReload = (count == reloadQ);

  // R2: no strobe and no write leaves the count alone
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == '0 && !cntWe) |=> $stable(count));
  // R3: an up-wrap lands on the reload value held in that cycle
  a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rldLoad && !cntWe) |=> count == $past(reloadQ));
  // R5: a down-wrap lands on all-ones
  a_r5_down_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.onesLoad && !cntWe) |=> count == ONES);
  // R7: the written count wins over any step
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |=> count == $past(cntWdata));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import updn_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              dirUp,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeWdata,
  input  logic              cntWe,
  input  logic              atMax,
  input  logic              atReload,
  output stepCmdT           cmd,
  output logic              ovfFlag,
  output logic              extFlag,
  output logic              clkOut
);
  logic              runQ;
  logic [MODE_W-1:0] modeQ;
  logic              modeBidir, modeClk;
  logic              active, goUp, wrapEvt;

  assign modeBidir = modeQ[MODE_BIDIR];
  assign modeClk   = modeQ[MODE_CLKOUT];

  always_comb begin
    active  = runQ && tick && !cntWe;
    goUp    = modeClk || !modeBidir || dirUp;
    wrapEvt = active && (goUp ? atMax : atReload);
    cmd.incr     = active && goUp && !atMax;
    cmd.rldLoad  = active && goUp && atMax;
    cmd.decr     = active && !goUp && !atReload;
    cmd.onesLoad = active && !goUp && atReload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      ovfFlag <= 1'b0;
      extFlag <= 1'b0;
    end else if (ctrlWe) begin
      runQ    <= ctrlWdata[CTRL_RUN];
      ovfFlag <= ctrlWdata[CTRL_OVF];
      extFlag <= ctrlWdata[CTRL_EXT];
    end else if (wrapEvt && !modeClk) begin
      ovfFlag <= 1'b1;
      if (modeBidir) extFlag <= ~extFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= '0;
    else if (modeWe) modeQ <= modeWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) clkOut <= 1'b0;
    else if (modeWe && !modeWdata[MODE_CLKOUT]) clkOut <= 1'b0;
    else if (wrapEvt && modeClk) clkOut <= ~clkOut;
  end

  // R4: at most one step strobe per cycle
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));
  // R3: event flag holds outside the bidirectional mode
  a_r3_ext_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!modeBidir && !ctrlWe) |=> $stable(extFlag));
  // R6: clock-output mode never raises the overflow flag
  a_r6_no_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (modeClk && !ctrlWe && !ovfFlag) |=> !ovfFlag);
  // R6: each wrap in clock-output mode flips the pin
  a_r6_clk_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && modeClk && !modeWe) |=> clkOut != $past(clkOut));
  // R2: nothing steps while stopped
  a_r2_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ || !tick) |-> cmd == '0);
  // R8: leaving clock-output mode parks the pin low
  a_r8_clk_park: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && !modeWdata[MODE_CLKOUT]) |=> !clkOut);
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import updn_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              dirUp,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeWdata,
  input  logic              cntWe,
  input  logic [W-1:0]      cntWdata,
  input  logic              rldWe,
  input  logic [W-1:0]      rldWdata,
  output logic [W-1:0]      count,
  output logic              ovfFlag,
  output logic              extFlag,
  output logic              clkOut
);
  stepCmdT cmd;
  logic    atMax, atReload;

  timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .dirUp(dirUp),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .modeWe(modeWe), .modeWdata(modeWdata),
    .cntWe(cntWe), .atMax(atMax), .atReload(atReload),
    .cmd(cmd), .ovfFlag(ovfFlag), .extFlag(extFlag), .clkOut(clkOut)
  );

  timer_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .cntWe(cntWe), .cntWdata(cntWdata),
    .rldWe(rldWe), .rldWdata(rldWdata),
    .count(count), .atMax(atMax), .atReload(atReload)
  );
endmodule

// File: tb/updn_reload_timer_tb.sv
module updn_reload_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 0, dirUp = 0, ctrlWe = 0, modeWe = 0, cntWe = 0, rldWe = 0;
  logic [2:0] ctrlWdata = '0;
  logic [1:0] modeWdata = '0;
  logic [15:0] cntWdata = '0, rldWdata = '0;
  logic [15:0] count;
  logic ovfFlag, extFlag, clkOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // model state
  logic [15:0] mCount = '0, mRld = '0;
  logic mRun = 0, mOvf = 0, mExt = 0, mClk = 0;
  logic [1:0] mMode = '0;

  always #2 clk = ~clk;

  updn_reload_timer u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .dirUp(dirUp),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .modeWe(modeWe), .modeWdata(modeWdata),
    .cntWe(cntWe), .cntWdata(cntWdata),
    .rldWe(rldWe), .rldWdata(rldWdata),
    .count(count), .ovfFlag(ovfFlag), .extFlag(extFlag), .clkOut(clkOut)
  );

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    checkVal(req, "count", int'(count), int'(mCount));
    checkVal(req, "ovfFlag", int'(ovfFlag), int'(mOvf));
    checkVal(req, "extFlag", int'(extFlag), int'(mExt));
    checkVal(req, "clkOut", int'(clkOut), int'(mClk));
  endtask

  // behaviour from the requirements, applied at each rising edge
  task automatic modelStep();
    logic up, act, wrap;
    logic [15:0] nCount;
    logic nOvf, nExt, nClk;
    if (!rstN) begin
      mCount = '0; mRld = '0; mRun = 0; mOvf = 0; mExt = 0; mClk = 0; mMode = '0;
      return;
    end
    up   = mMode[1] || !mMode[0] || dirUp;
    act  = mRun && tick && !cntWe;
    wrap = act && (up ? (mCount == 16'hFFFF) : (mCount == mRld));
    nCount = mCount;
    if (cntWe) nCount = cntWdata;
    else if (act) begin
      if (up) nCount = (mCount == 16'hFFFF) ? mRld : mCount + 16'd1;
      else    nCount = (mCount == mRld) ? 16'hFFFF : mCount - 16'd1;
    end
    nOvf = mOvf; nExt = mExt; nClk = mClk;
    if (ctrlWe) begin
      mRun = ctrlWdata[0]; nOvf = ctrlWdata[1]; nExt = ctrlWdata[2];
    end else if (wrap && !mMode[1]) begin
      nOvf = 1'b1;
      if (mMode[0]) nExt = ~mExt;
    end
    if (modeWe && !modeWdata[1]) nClk = 1'b0;
    else if (wrap && mMode[1]) nClk = ~mClk;
    if (rldWe) mRld = rldWdata;
    if (modeWe) mMode = modeWdata;
    mCount = nCount; mOvf = nOvf; mExt = nExt; mClk = nClk;
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    ctrlWe = 0; modeWe = 0; cntWe = 0; rldWe = 0;
  endtask

  function automatic string modeTag();
    if (mMode[1]) return "R6";
    if (mMode[0]) return dirUp ? "R4" : "R5";
    return "R3";
  endfunction

  task automatic wrCtrl(logic [2:0] v); ctrlWe = 1; ctrlWdata = v; endtask
  task automatic wrMode(logic [1:0] v); modeWe = 1; modeWdata = v; endtask
  task automatic wrCnt(logic [15:0] v); cntWe = 1; cntWdata = v; endtask
  task automatic wrRld(logic [15:0] v); rldWe = 1; rldWdata = v; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) cycle();
    rstN = 1;
    // R1 reset state
    checkVal("R1", "count", int'(count), 0);
    checkVal("R1", "ovfFlag", int'(ovfFlag), 0);
    checkVal("R1", "extFlag", int'(extFlag), 0);
    checkVal("R1", "clkOut", int'(clkOut), 0);

    // R2: stopped timer ignores ticks
    wrCnt(16'h0005); cycle();
    tick = 1; repeat (3) cycle();
    checkVal("R2", "count stopped", int'(count), 5);
    tick = 0; wrCtrl(3'b001); cycle(); repeat (2) cycle();
    checkVal("R2", "count no tick", int'(count), 5);
    checkAll("R2");

    // R3: up count, reload on wrap, direction pin ignored
    dirUp = 0; wrRld(16'h1234); wrCnt(16'hFFFE); cycle();
    tick = 1; cycle();
    checkVal("R3", "count", int'(count), 16'hFFFF);
    cycle();
    checkVal("R3", "count reload", int'(count), 16'h1234);
    checkVal("R3", "ovfFlag", int'(ovfFlag), 1);
    checkVal("R3", "extFlag", int'(extFlag), 0);
    checkAll("R3");

    // R7: control write clears flags; count write beats tick
    wrCtrl(3'b001); wrCnt(16'h0100); cycle();
    checkVal("R7", "count load beats tick", int'(count), 16'h0100);
    checkVal("R7", "ovf cleared", int'(ovfFlag), 0);
    tick = 0; wrRld(16'h0200); cycle();
    checkVal("R7", "reload write leaves count", int'(count), 16'h0100);

    // R4: bidirectional up wrap
    wrMode(2'b01); wrCnt(16'hFFFF); cycle();
    dirUp = 1; tick = 1; cycle();
    checkVal("R4", "count", int'(count), 16'h0200);
    checkVal("R4", "extFlag", int'(extFlag), 1);
    checkVal("R4", "ovfFlag", int'(ovfFlag), 1);

    // R5: down count to reload then all-ones
    tick = 0; wrCnt(16'h0201); cycle();
    dirUp = 0; tick = 1; cycle();
    checkVal("R5", "count dec", int'(count), 16'h0200);
    cycle();
    checkVal("R5", "count wrap", int'(count), 16'hFFFF);
    checkVal("R5", "extFlag", int'(extFlag), 0);
    checkAll("R5");
    // R5: below reload wraps 0 to all-ones without flags
    tick = 0; wrCtrl(3'b001); wrCnt(16'h0000); cycle();
    tick = 1; cycle();
    checkVal("R5", "count below reload", int'(count), 16'hFFFF);
    checkVal("R5", "no ovf", int'(ovfFlag), 0);

    // R6: clock output, half period 4 ticks with reload FFFC
    tick = 0; wrMode(2'b11); wrRld(16'hFFFC); wrCnt(16'hFFFC); cycle();
    tick = 1; repeat (4) cycle();
    checkVal("R6", "clkOut first half", int'(clkOut), 1);
    repeat (3) cycle();
    checkVal("R6", "clkOut mid", int'(clkOut), 1);
    cycle();
    checkVal("R6", "clkOut second half", int'(clkOut), 0);
    repeat (4) cycle();
    checkVal("R6", "ovf untouched", int'(ovfFlag), 0);
    checkAll("R6");

    // R8: leaving clock mode parks pin
    checkVal("R8", "clkOut before", int'(clkOut), 1);
    tick = 0; wrMode(2'b00); cycle();
    checkVal("R8", "clkOut parked", int'(clkOut), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick  = ($urandom % 4) != 0;
      dirUp = $urandom % 2;
      if (($urandom % 40) == 0) wrMode(2'($urandom));
      if (($urandom % 50) == 0) wrCtrl({2'($urandom), 1'b1});
      if (($urandom % 60) == 0) wrCtrl(3'($urandom));
      if (($urandom % 30) == 0) wrCnt(16'hFFF0 + 16'($urandom % 16));
      if (($urandom % 30) == 0) wrCnt(mRld + 16'($urandom % 4));
      if (($urandom % 45) == 0) wrRld(16'hFFF0 + 16'($urandom % 16));
      begin
        string tag;
        tag = modeTag();
        cycle();
        checkAll(tag);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule